// File: doc/BRIEF.md
# Cyclic I/O Request Scanner with Autonomous Word Buffering

The block watches eight request sources in a fixed rotation: three peripheral-to-memory (input) channels at positions 0 to 2, three memory-to-peripheral (output) channels at positions 3 to 5, an interrupt line at position 6 and a real-time clock tick at position 7. Each source raises a ready flag. When the scanner reaches a flagged input or output channel that software has armed, it stops rotating and moves one data word between that channel and memory through a valid/ready request port. It then continues at the next position. The pause lasts until the memory accepts the word.

Software arms a channel once, with a start address and a word count. After that every word moves without any further help from software. The channel address counts up and the remaining count counts down. When the last word has moved, the channel disarms itself and raises a sticky completion bit.

A hit on the interrupt position latches a pending-interrupt output. A hit on the clock position advances a real-time counter. Neither of these makes a memory access, and neither adds a cycle to the rotation. A sweep with no transfers takes exactly `SWEEP_CLKS` clocks, shared evenly at `SWEEP_CLKS/8` clocks per position.

States of the controller:
- `ST_PROBE`: the first cycle at a position, when the flag is inspected.
- `ST_DWELL`: the remaining cycles at that position.
- `ST_XFER`: the memory request is outstanding.

Transitions of the controller:
- PROBE to XFER: the position is an armed channel and its flag is raised.
- PROBE to DWELL: no transfer, and the dwell is longer than one cycle.
- PROBE to PROBE at the next position: no transfer, and the dwell is one cycle.
- DWELL to DWELL: the dwell count has not reached the end.
- DWELL to PROBE at the next position: the dwell count has ended.
- XFER to XFER: the memory is not ready.
- XFER to PROBE at the next position: the memory is ready.

Top module: `chscan_top`

## Requirements
- R1: After reset the block drives these values: no memory request, no acknowledge or strobe pulses, all completion bits 0, interrupt pending 0 and real-time counter 0. The scan starts at position 0.
- R2: Positions are visited in the order 0,1,...,7 and then back to 0. Each position is held for `SWEEP_CLKS/8` cycles. A sweep with no transfers lasts exactly `SWEEP_CLKS` cycles. When every channel is armed and flagged, transfers occur in channel order 0..5 and this order repeats.
- R3: A hit on armed input channel i (i = 0..2) issues a write request (`mem_req_we`=1). The write carries the channel's current address and the 48-bit word from slice i of `in_word` (bits i*48 up to i*48+47), latched in the probe cycle. `in_ack[i]` pulses for one cycle, in the cycle after the memory accepts the request.
- R4: A hit on armed output channel j (j = 3..5) issues a read request (`mem_req_we`=0). In the cycle after acceptance, `out_word` holds the `mem_rsp_data` that was presented with the accepting `mem_req_ready`, and `out_strobe[j-3]` pulses for one cycle.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request holds its address, direction and data unchanged. During this time the scan does not move and the real-time counter does not change.
- R6: The cycle after acceptance probes the position after the one served. Consecutive accepts are therefore spaced by 2 + dwell × (number of positions skipped) cycles when memory is ready at once.
- R7: Each transferred word increments the channel address by 1 and decrements its count by 1. When the last word is accepted, the channel disarms and its `xfer_done` bit is set in the following cycle. A new arm of that channel clears the bit.
- R8: A raised flag on an unarmed channel is ignored: no request is issued and the scan proceeds.
- R9: A flag seen at position 6 sets `irq_pending` without any memory access. `irq_ack` clears it when no new hit occurs in the same cycle.
- R10: A flag seen at position 7 increments `rtc_count` by exactly one per visit, without any memory access.
- R11: An arm command with a zero word count is ignored. The channel stays unarmed and its completion bit is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm command strobe |
| arm_chan | input | 3 | Channel to arm (0..5; 6 and 7 ignored) |
| arm_addr | input | ADDR_W | Start address |
| arm_count | input | CNT_W | Word count |
| src_ready | input | 8 | Ready flags, bit = scan position |
| in_word | input | 3*DATA_W | Input channel words, slice i for channel i |
| in_ack | output | 3 | Word taken from input channel |
| out_word | output | DATA_W | Word for an output channel |
| out_strobe | output | 3 | out_word valid for output channel 3+k |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_data | input | DATA_W | Read data, valid with mem_req_ready |
| xfer_done | output | 6 | Sticky per-channel completion bits |
| irq_pending | output | 1 | Latched interrupt request |
| irq_ack | input | 1 | Clears irq_pending |
| rtc_count | output | RTC_W | Real-time tick counter |

## Verification
The bench raises the flags of unarmed channels and checks that no request appears. A design that skipped the arm test would write memory on its own. It holds memory ready off for several cycles and checks that the request stays stable and the clock counter stays frozen. A scanner that kept sweeping would lose ticks or corrupt the pending transfer. With every channel armed and flagged, it checks the exact service order and the spacing between accepts, including the wrap from position 5 over 6 and 7 back to 0. This exposes a priority arbiter, or a resume from the wrong position. It also checks that a zero-count arm is ignored and that completion bits set on the last word and clear on a re-arm.

// File: rtl/chscan_pkg.sv
package chscan_pkg;
    localparam int NSRC  = 8;
    localparam int NIN   = 3;
    localparam int NOUT  = 3;
    localparam int NCHAN = NIN + NOUT;

    typedef logic [2:0] src_idx_t;

    localparam src_idx_t SRC_IRQ = 3'd6;
    localparam src_idx_t SRC_RTC = 3'd7;

    typedef enum logic [1:0] {
        ST_PROBE = 2'd0,
        ST_DWELL = 2'd1,
        ST_XFER  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/chscan_ctrl.sv
module chscan_ctrl
    import chscan_pkg::*;
#(
    parameter int DWELL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_ready,
    input  logic [NCHAN-1:0] armed,
    input  logic             mem_ready,
    output src_idx_t         pos,
    output logic             xfer_active,
    output logic             word_done,
    output logic             mem_hit,
    output logic             irq_hit,
    output logic             rtc_hit
);
    localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

    scan_state_e       state_q, state_d;
    src_idx_t          pos_q, pos_d;
    logic [DW_W-1:0]   cnt_q, cnt_d;
    logic [NSRC-1:0]   armed_ext;
    logic              probe_mem_hit;

    always_comb begin
        armed_ext     = {{(NSRC - NCHAN){1'b0}}, armed};
        probe_mem_hit = src_ready[pos_q] && armed_ext[pos_q];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PROBE: begin
                if (probe_mem_hit) begin
                    state_d = ST_XFER;
                end else if (DWELL > 1) begin
                    state_d = ST_DWELL;
                    cnt_d   = DW_W'(1);
                end else begin
                    pos_d   = pos_q + src_idx_t'(1);
                end
            end
            ST_DWELL: begin
                if (cnt_q == DW_LAST) begin
                    state_d = ST_PROBE;
                    pos_d   = pos_q + src_idx_t'(1);
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + DW_W'(1);
                end
            end
            ST_XFER: begin
                if (mem_ready) begin
                    state_d = ST_PROBE;
                    pos_d   = pos_q + src_idx_t'(1);
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_PROBE;
                pos_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE;
            pos_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        pos         = pos_q;
        xfer_active = (state_q == ST_XFER);
        word_done   = (state_q == ST_XFER) && mem_ready;
        mem_hit     = (state_q == ST_PROBE) && probe_mem_hit;
        irq_hit     = (state_q == ST_PROBE) && (pos_q == SRC_IRQ) && src_ready[SRC_IRQ];
        rtc_hit     = (state_q == ST_PROBE) && (pos_q == SRC_RTC) && src_ready[SRC_RTC];
    end
endmodule

// File: rtl/chscan_bank.sv
module chscan_bank
    import chscan_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int CNT_W  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm_valid,
    input  logic [2:0]                    arm_chan,
    input  logic [ADDR_W-1:0]             arm_addr,
    input  logic [CNT_W-1:0]              arm_count,
    input  logic                          word_done,
    input  src_idx_t                      pos,
    output logic [NCHAN-1:0]              armed,
    output logic [NCHAN-1:0]              done,
    output logic [NCHAN-1:0][ADDR_W-1:0]  cur_addr
);
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic [ADDR_W-1:0] addr_q;
        logic [CNT_W-1:0]  left_q;
        logic              done_q;
        logic              load;
        logic              step;

        always_comb begin
            load = arm_valid && (arm_chan == 3'(c)) && (arm_count != '0);
            step = word_done && (pos == src_idx_t'(c));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                left_q <= '0;
                done_q <= 1'b0;
            end else if (load) begin
                addr_q <= arm_addr;
                left_q <= arm_count;
                done_q <= 1'b0;
            end else if (step) begin
                addr_q <= addr_q + ADDR_W'(1);
                left_q <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end

        assign armed[c]    = (left_q != '0);
        assign done[c]     = done_q;
        assign cur_addr[c] = addr_q;
    end
endmodule

// File: rtl/chscan_event.sv
module chscan_event #(
    parameter int RTC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_hit,
    input  logic             irq_ack,
    input  logic             rtc_hit,
    output logic             irq_pending,
    output logic [RTC_W-1:0] rtc_count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pending <= 1'b0;
            rtc_count   <= '0;
        end else begin
            if (irq_hit) begin
                irq_pending <= 1'b1;
            end else if (irq_ack) begin
                irq_pending <= 1'b0;
            end
            if (rtc_hit) begin
                rtc_count <= rtc_count + RTC_W'(1);
            end
        end
    end
endmodule

// File: rtl/chscan_top.sv
module chscan_top
    import chscan_pkg::*;
#(
    parameter int DATA_W     = 48,
    parameter int ADDR_W     = 15,
    parameter int CNT_W      = 15,
    parameter int RTC_W      = 16,
    parameter int SWEEP_CLKS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm_valid,
    input  logic [2:0]            arm_chan,
    input  logic [ADDR_W-1:0]     arm_addr,
    input  logic [CNT_W-1:0]      arm_count,
    input  logic [7:0]            src_ready,
    input  logic [3*DATA_W-1:0]   in_word,
    output logic [2:0]            in_ack,
    output logic [DATA_W-1:0]     out_word,
    output logic [2:0]            out_strobe,
    output logic                  mem_req_valid,
    output logic                  mem_req_we,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [DATA_W-1:0]     mem_req_wdata,
    input  logic                  mem_req_ready,
    input  logic [DATA_W-1:0]     mem_rsp_data,
    output logic [5:0]            xfer_done,
    output logic                  irq_pending,
    input  logic                  irq_ack,
    output logic [RTC_W-1:0]      rtc_count
);
    localparam int DWELL = (SWEEP_CLKS / NSRC > 0) ? SWEEP_CLKS / NSRC : 1;

    src_idx_t                     pos;
    logic                         xfer_active;
    logic                         word_done;
    logic                         mem_hit;
    logic                         irq_hit;
    logic                         rtc_hit;
    logic [NCHAN-1:0]             armed;
    logic [NCHAN-1:0][ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0]            wdata_q;
    logic [DATA_W-1:0]            out_q;
    logic [NIN-1:0]               ack_q;
    logic [NOUT-1:0]              strobe_q;

    chscan_ctrl #(
        .DWELL (DWELL)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_ready   (src_ready),
        .armed       (armed),
        .mem_ready   (mem_req_ready),
        .pos         (pos),
        .xfer_active (xfer_active),
        .word_done   (word_done),
        .mem_hit     (mem_hit),
        .irq_hit     (irq_hit),
        .rtc_hit     (rtc_hit)
    );

    chscan_bank #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_valid (arm_valid),
        .arm_chan  (arm_chan),
        .arm_addr  (arm_addr),
        .arm_count (arm_count),
        .word_done (word_done),
        .pos       (pos),
        .armed     (armed),
        .done      (xfer_done),
        .cur_addr  (cur_addr)
    );

    chscan_event #(
        .RTC_W (RTC_W)
    ) u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_hit     (irq_hit),
        .irq_ack     (irq_ack),
        .rtc_hit     (rtc_hit),
        .irq_pending (irq_pending),
        .rtc_count   (rtc_count)
    );

    // request side: address of the served channel, direction from position
    always_comb begin
        mem_req_addr = '0;
        for (int i = 0; i < NCHAN; i++) begin
            if (pos == src_idx_t'(i)) begin
                mem_req_addr = cur_addr[i];
            end
        end
        mem_req_valid = xfer_active;
        mem_req_we    = xfer_active && (pos < src_idx_t'(NIN));
        mem_req_wdata = wdata_q;
    end

    // input word is captured in the probe cycle so it stays stable under stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (mem_hit) begin
            for (int i = 0; i < NIN; i++) begin
                if (pos == src_idx_t'(i)) begin
                    wdata_q <= in_word[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    // completion pulses toward the peripherals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= '0;
            strobe_q <= '0;
            out_q    <= '0;
        end else begin
            ack_q    <= '0;
            strobe_q <= '0;
            if (word_done) begin
                for (int i = 0; i < NIN; i++) begin
                    if (pos == src_idx_t'(i)) begin
                        ack_q[i] <= 1'b1;
                    end
                end
                for (int k = 0; k < NOUT; k++) begin
                    if (pos == src_idx_t'(NIN + k)) begin
                        strobe_q[k] <= 1'b1;
                        out_q       <= mem_rsp_data;
                    end
                end
            end
        end
    end

    assign in_ack     = ack_q;
    assign out_strobe = strobe_q;
    assign out_word   = out_q;
endmodule

// File: rtl/chscan_chk.sv
module chscan_chk #(
    parameter int DATA_W = 48,
    parameter int ADDR_W = 15,
    parameter int RTC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic [2:0]        in_ack,
    input logic [2:0]        out_strobe,
    input logic [5:0]        xfer_done,
    input logic              irq_pending,
    input logic [RTC_W-1:0]  rtc_count
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata))); // R5

    AST_RTC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> $stable(rtc_count)); // R5

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ack)); // R3

    AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != 3'b000) |-> $past(mem_req_valid && mem_req_ready && mem_req_we)); // R3

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_strobe)); // R4

    AST_STROBE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe != 3'b000) |-> $past(mem_req_valid && mem_req_ready && !mem_req_we)); // R4

    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_done & ~$past(xfer_done)) != 6'b0) |-> $past(mem_req_valid && mem_req_ready)); // R7

    AST_IRQ_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(!mem_req_valid)); // R9

    AST_RTC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_count != $past(rtc_count)) |-> (rtc_count == RTC_W'($past(rtc_count) + 1'b1))); // R10
endmodule

bind chscan_top chscan_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RTC_W  (RTC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .in_ack        (in_ack),
    .out_strobe    (out_strobe),
    .xfer_done     (xfer_done),
    .irq_pending   (irq_pending),
    .rtc_count     (rtc_count)
);

// File: tb/chscan_top_test.sv
module chscan_top_test;
    localparam int DATA_W = 48;
    localparam int ADDR_W = 15;
    localparam int CNT_W  = 15;
    localparam int RTC_W  = 16;
    localparam int SWEEP  = 16;
    localparam int DWELL  = SWEEP / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_valid = 1'b0;
    logic [2:0] arm_chan = '0;
    logic [ADDR_W-1:0] arm_addr = '0;
    logic [CNT_W-1:0] arm_count = '0;
    logic [7:0] src_ready = '0;
    logic [3*DATA_W-1:0] in_word;
    logic [2:0] in_ack;
    logic [DATA_W-1:0] out_word;
    logic [2:0] out_strobe;
    logic mem_req_valid, mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic mem_req_ready = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic [5:0] xfer_done;
    logic irq_pending;
    logic irq_ack = 1'b0;
    logic [RTC_W-1:0] rtc_count;

    chscan_top #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RTC_W(RTC_W), .SWEEP_CLKS(SWEEP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_chan(arm_chan),
        .arm_addr(arm_addr), .arm_count(arm_count), .src_ready(src_ready),
        .in_word(in_word), .in_ack(in_ack), .out_word(out_word), .out_strobe(out_strobe),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
        .mem_rsp_data(mem_rsp_data), .xfer_done(xfer_done), .irq_pending(irq_pending),
        .irq_ack(irq_ack), .rtc_count(rtc_count)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int mem_lat = 0;
    int wcnt = 0;
    int valid_seen = 0;
    int exp_left [6];
    int exp_addr [6];
    int in_k [6];
    logic [5:0] exp_done = '0;
    int log_c [64];
    int log_cyc [64];
    int n_log = 0;
    bit pend_rd = 0, pend_wr = 0;
    int pend_c = 0;
    logic [DATA_W-1:0] pend_d = '0;
    bit prev_valid = 0;
    logic [RTC_W-1:0] prev_rtc = '0;

    function automatic logic [DATA_W-1:0] inval(int c, int k);
        return 48'hA5A5_0000_0000 + DATA_W'(c * 65536) + DATA_W'(k);
    endfunction

    function automatic logic [DATA_W-1:0] rdv(logic [ADDR_W-1:0] a);
        return 48'hC0DE_0000_0000 | DATA_W'(a);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // memory model and transfer monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_rd || out_strobe != 3'b000) begin
                chk(pend_rd && out_strobe == 3'(1 << (pend_c - 3)), "R4 strobe", out_strobe, pend_rd ? (1 << (pend_c - 3)) : 0);
                if (pend_rd) chk(out_word == pend_d, "R4 data", out_word, pend_d);
            end
            if (pend_wr || in_ack != 3'b000) begin
                chk(pend_wr && in_ack == 3'(1 << pend_c), "R3 ack", in_ack, pend_wr ? (1 << pend_c) : 0);
                if (pend_wr) begin
                    in_k[pend_c]++;
                    in_word[pend_c*DATA_W +: DATA_W] = inval(pend_c, in_k[pend_c]);
                end
            end
            pend_rd = 0;
            pend_wr = 0;
            if (mem_req_valid && prev_valid && mem_lat > 0)
                chk(rtc_count == prev_rtc, "R5 rtc frozen", rtc_count, prev_rtc);
            prev_valid = mem_req_valid;
            prev_rtc = rtc_count;
            if (mem_req_valid) begin
                valid_seen++;
                if (wcnt == mem_lat) begin
                    int c;
                    c = int'(mem_req_addr >> 6);
                    mem_req_ready = 1'b1;
                    wcnt = 0;
                    chk(c < 6 && exp_left[c % 8 < 6 ? c : 0] > 0, "R8 unarmed request", mem_req_addr, 0);
                    if (c < 6) begin
                        chk(mem_req_addr == ADDR_W'(exp_addr[c]), "R7 address", mem_req_addr, exp_addr[c]);
                        chk(mem_req_we == (c < 3), "R3 direction", mem_req_we, (c < 3));
                        if (c < 3) begin
                            chk(mem_req_wdata == inval(c, in_k[c]), "R3 write data", mem_req_wdata, inval(c, in_k[c]));
                            pend_wr = 1;
                        end else begin
                            mem_rsp_data = rdv(mem_req_addr);
                            pend_d = mem_rsp_data;
                            pend_rd = 1;
                        end
                        pend_c = c;
                        exp_addr[c]++;
                        exp_left[c]--;
                        if (exp_left[c] == 0) exp_done[c] = 1'b1;
                        if (n_log < 64) begin
                            log_c[n_log] = c;
                            log_cyc[n_log] = cyc;
                            n_log++;
                        end
                    end
                end else begin
                    mem_req_ready = 1'b0;
                    wcnt++;
                end
            end else begin
                mem_req_ready = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic arm(input int c, input int a, input int n);
        @(negedge clk);
        arm_valid = 1'b1;
        arm_chan  = 3'(c);
        arm_addr  = ADDR_W'(a);
        arm_count = CNT_W'(n);
        if (n != 0 && c < 6) begin
            exp_addr[c] = a;
            exp_left[c] = n;
            exp_done[c] = 1'b0;
        end
        @(negedge clk);
        arm_valid = 1'b0;
    endtask

    task automatic wait_idle(input int maxc);
        int left;
        for (int t = 0; t < maxc; t++) begin
            @(negedge clk);
            left = 0;
            for (int c = 0; c < 6; c++) left += exp_left[c];
            if (left == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int r0, t0, left;
        for (int c = 0; c < 6; c++) begin
            exp_left[c] = 0;
            exp_addr[c] = 0;
            in_k[c] = 0;
        end
        for (int c = 0; c < 3; c++) in_word[c*DATA_W +: DATA_W] = inval(c, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        chk(mem_req_valid == 1'b0, "R1 valid", mem_req_valid, 0);
        chk(out_strobe == 3'b0 && in_ack == 3'b0, "R1 pulses", {out_strobe, in_ack}, 0);
        chk(xfer_done == 6'b0, "R1 done", xfer_done, 0);
        chk(irq_pending == 1'b0 && rtc_count == '0, "R1 irq/rtc", {irq_pending, rtc_count}, 0);

        // R8: flags on unarmed channels
        valid_seen = 0;
        src_ready = 8'h3F;
        repeat (3 * SWEEP) @(negedge clk);
        chk(valid_seen == 0, "R8 no request", valid_seen, 0);
        src_ready = 8'h00;

        // R2 / R10: sweep period measured through clock hits
        src_ready = 8'h80;
        r0 = int'(rtc_count);
        for (int t = 0; t < 3 * SWEEP && int'(rtc_count) == r0; t++) @(negedge clk);
        t0 = cyc;
        for (int k = 0; k < 4; k++) begin
            r0 = int'(rtc_count);
            for (int t = 0; t < 3 * SWEEP && int'(rtc_count) == r0; t++) @(negedge clk);
            chk(cyc - t0 == SWEEP, "R2 sweep period", cyc - t0, SWEEP);
            chk(int'(rtc_count) == r0 + 1, "R10 tick", rtc_count, r0 + 1);
            t0 = cyc;
        end
        src_ready = 8'h00;

        // R9: interrupt
        valid_seen = 0;
        src_ready = 8'h40;
        repeat (SWEEP + 4) @(negedge clk);
        src_ready = 8'h00;
        chk(irq_pending == 1'b1, "R9 set", irq_pending, 1);
        chk(valid_seen == 0, "R9 no memory", valid_seen, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq_pending == 1'b0, "R9 ack", irq_pending, 0);

        // R11: zero-count arm
        valid_seen = 0;
        arm(2, 128, 0);
        src_ready = 8'h04;
        repeat (2 * SWEEP) @(negedge clk);
        src_ready = 8'h00;
        chk(valid_seen == 0, "R11 no request", valid_seen, 0);
        chk(xfer_done[2] == 1'b0, "R11 not armed", xfer_done[2], 0);

        // R3 / R7: input channel 1, three words
        arm(1, 64, 3);
        src_ready = 8'h02;
        wait_idle(400);
        src_ready = 8'h00;
        chk(exp_left[1] == 0, "R3 words moved", exp_left[1], 0);
        chk(xfer_done == exp_done, "R7 done bits", xfer_done, exp_done);

        // R4 / R5: output channel 4 with slow memory, clock running
        mem_lat = 3;
        arm(4, 256, 3);
        src_ready = 8'h90;
        wait_idle(400);
        src_ready = 8'h00;
        mem_lat = 0;
        chk(exp_left[4] == 0, "R4 words moved", exp_left[4], 0);
        chk(xfer_done == exp_done, "R7 done bits", xfer_done, exp_done);

        // R7: re-arm clears completion, then sets again
        arm(1, 74, 1);
        chk(xfer_done[1] == 1'b0, "R7 clear on arm", xfer_done[1], 0);
        src_ready = 8'h02;
        wait_idle(200);
        src_ready = 8'h00;
        chk(xfer_done == exp_done, "R7 done after re-arm", xfer_done, exp_done);

        // R2 / R6: all channels armed, order and spacing
        for (int c = 0; c < 6; c++) arm(c, c * 64 + 20, 2);
        n_log = 0;
        src_ready = 8'h3F;
        wait_idle(600);
        src_ready = 8'h00;
        chk(n_log == 12, "R2 transfer count", n_log, 12);
        for (int i = 1; i < 12 && i < n_log; i++) begin
            int pc, nc, gap;
            pc = log_c[i-1];
            nc = log_c[i];
            gap = 2 + DWELL * ((nc - pc - 1 + 16) % 8);
            chk(nc == (pc + 1) % 6, "R2 order", nc, (pc + 1) % 6);
            chk(log_cyc[i] - log_cyc[i-1] == gap, "R6 resume spacing", log_cyc[i] - log_cyc[i-1], gap);
        end
        chk(xfer_done == exp_done, "R7 done all", xfer_done, exp_done);
        left = 0;
        for (int c = 0; c < 6; c++) left += exp_left[c];
        chk(left == 0, "R7 counts exhausted", left, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule